// File: doc/BRIEF.md
# Index-Next-Instruction Fetch Modifier

This block sits between instruction fetch and the instruction register of a small accumulator machine. When the decoder executes an INDEX instruction, it pulses `index_req`. That pulse arms a one-shot modification. The next word that arrives from program memory is read in the usual way. The instruction register does not take that word as it is. It takes the word added to the current accumulator, and the machine then decodes and executes that sum as an ordinary instruction. Program memory is never written, so code in read-only storage behaves the same as code in RAM.

A two-state machine holds the arming. The states are `ST_IDLE` (fetches pass through) and `ST_ARMED` (the next fetch is modified). It has these transitions:
- **arm**: `index_req` moves IDLE to ARMED.
- **consume**: a fetch in ARMED without `index_req` returns to IDLE.
- **re-arm**: a fetch in ARMED together with `index_req` stays in ARMED.
- **hold**: ARMED is kept while no fetch arrives.
- **flush**: a flush or reset sends the machine to IDLE from any state.

An `index_req` takes effect only for fetches in later cycles. The instruction register is loaded on the clock edge that ends a `fetch_valid` cycle. `ir_valid` is high in the cycle that follows.

Top module: `idx_fetch_mod`

## Requirements
- R1: After reset, `ir_valid` is 0, `ir_word` is 0 and the block is not armed, so the first fetch after reset is latched unmodified.
- R2: When armed and not flushed, a fetch loads `ir_word` with (fetch word + accumulator) mod 2^18. The result appears after the clock edge that ends the fetch cycle.
- R3: When not armed, a fetch loads `ir_word` with the fetched word unchanged, on the same edge.
- R4: `ir_valid` is high in exactly the cycles that follow a `fetch_valid` cycle. `ir_word` holds its value when there is no fetch.
- R5: The arming covers one fetch only. The fetch after a modified one is unmodified unless INDEX re-armed.
- R6: An `index_req` in the same cycle as the modified fetch arms the block again for the following fetch.
- R7: `flush` clears the arming, even when `index_req` is high in the same cycle. A fetch in a flush cycle is latched unmodified.
- R8: The arming persists across any number of cycles without `fetch_valid`.
- R9: The accumulator value added is the one present in the fetch cycle, not the one present when INDEX was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush; cancels any pending modification |
| index_req | input | 1 | Pulse from the decoder: an INDEX instruction executed |
| fetch_valid | input | 1 | Fetched word is present this cycle |
| fetch_word | input | 18 | Word read from program memory |
| acc | input | 18 | Current accumulator value |
| ir_word | output | 18 | Instruction register contents |
| ir_valid | output | 1 | Instruction register was loaded on the last edge |

## Verification
The bench builds the block with the default 18-bit width. With that width, all-ones words and accumulators make the modulo-2^18 wrap of the sum easy to hit. Random traffic sets `index_req`, `flush` and `fetch_valid` together in the same cycle. This covers the re-arm and flush-priority corners. Directed runs separate the accumulator value at INDEX time from the value at fetch time, and leave long gaps between arming and the fetch.

// File: rtl/idx_fetch_pkg.sv
package idx_fetch_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;
endpackage

// File: rtl/idx_wrap_add.sv
module idx_wrap_add #(
    parameter int W = 18
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // carry out of the top bit is discarded: modulo 2^W
    always_comb y = a + b;
endmodule

// File: rtl/idx_arm_fsm.sv
module idx_arm_fsm
    import idx_fetch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic index_req,
    input  logic fetch_valid,
    output logic armed
);
    arm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (index_req) state_d = ST_ARMED;              // arm
            end
            ST_ARMED: begin
                if (fetch_valid && !index_req) state_d = ST_IDLE; // consume
            end
            default: state_d = ST_IDLE;
        endcase
        if (flush) state_d = ST_IDLE;                           // flush
    end

    always_comb armed = (state_q == ST_ARMED);

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !armed);
    // R6
    index_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (index_req && !flush) |=> armed);
    // R5
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fetch_valid && !index_req) |=> !armed);
    // R8
    hold_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !fetch_valid && !flush) |=> armed);
endmodule

// File: rtl/idx_ir_reg.sv
module idx_ir_reg #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         use_sum,
    input  logic [W-1:0] raw_word,
    input  logic [W-1:0] sum_word,
    output logic [W-1:0] ir_word,
    output logic         ir_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_word  <= '0;
            ir_valid <= 1'b0;
        end else begin
            ir_valid <= load;
            if (load) ir_word <= use_sum ? sum_word : raw_word;
        end
    end

    // R3
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !use_sum) |=> ir_word == $past(raw_word));
    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ir_valid);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (!ir_valid && $stable(ir_word)));
endmodule

// File: rtl/idx_fetch_mod.sv
module idx_fetch_mod #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         index_req,
    input  logic         fetch_valid,
    input  logic [W-1:0] fetch_word,
    input  logic [W-1:0] acc,
    output logic [W-1:0] ir_word,
    output logic         ir_valid
);
    logic         armed;
    logic         use_sum;
    logic [W-1:0] sum_word;

    idx_arm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .index_req  (index_req),
        .fetch_valid(fetch_valid),
        .armed      (armed)
    );

    idx_wrap_add #(.W(W)) u_add (
        .a(fetch_word),
        .b(acc),
        .y(sum_word)
    );

    always_comb use_sum = armed && !flush;

    idx_ir_reg #(.W(W)) u_ir (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fetch_valid),
        .use_sum (use_sum),
        .raw_word(fetch_word),
        .sum_word(sum_word),
        .ir_word (ir_word),
        .ir_valid(ir_valid)
    );

    // R2
    modified_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fetch_valid && !flush) |=>
            ir_word == W'($past(fetch_word) + $past(acc)));
    // R7
    flush_unmod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && fetch_valid) |=> ir_word == $past(fetch_word));
endmodule

// File: tb/idx_fetch_mod_tb.sv
module idx_fetch_mod_tb;
    localparam int W = 18;
    localparam logic [W-1:0] MASK = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         index_req = 1'b0;
    logic         fetch_valid = 1'b0;
    logic [W-1:0] fetch_word = '0;
    logic [W-1:0] acc = '0;
    logic [W-1:0] ir_word;
    logic         ir_valid;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit           m_armed = 1'b0;
    bit           m_prev_mod = 1'b0;
    logic [W-1:0] m_ir = '0;
    bit           m_val = 1'b0;
    string        m_tag = "R1";

    always #5 clk = ~clk;

    idx_fetch_mod #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .index_req(index_req),
        .fetch_valid(fetch_valid), .fetch_word(fetch_word), .acc(acc),
        .ir_word(ir_word), .ir_valid(ir_valid)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_armed = 0; m_ir = '0; m_val = 0; m_tag = "R1"; m_prev_mod = 0;
        end else begin
            m_val = fetch_valid;
            if (fetch_valid) begin
                if (m_armed && !flush) begin
                    m_ir = (fetch_word + acc) & MASK; m_tag = "R2"; m_prev_mod = 1;
                end else begin
                    m_ir = fetch_word;
                    m_tag = flush ? "R7" : (m_prev_mod ? "R5" : "R3");
                    m_prev_mod = 0;
                end
            end
            if (flush) m_armed = 0;
            else if (index_req) m_armed = 1;
            else if (fetch_valid) m_armed = 0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check("R4 ir_valid", {{(W-1){1'b0}}, ir_valid}, {{(W-1){1'b0}}, m_val});
            check({m_tag, " ir_word"}, ir_word, m_ir);
        end
    end

    task automatic step(input bit ix, input bit fv, input logic [W-1:0] w,
                        input logic [W-1:0] a, input bit fl);
        index_req = ix; fetch_valid = fv; fetch_word = w; acc = a; flush = fl;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {{(W-1){1'b0}}, ir_valid}, '0);
        check("R1 reset word", ir_word, '0);
        rst_n = 1'b1;
        step(0, 1, 18'h00123, 18'h00777, 0);
        check("R1 first fetch unmodified", ir_word, 18'h00123);
        // R2 with wrap
        step(1, 0, '0, '0, 0);
        step(0, 1, 18'h3FFFF, 18'h00002, 0);
        check("R2 wrap", ir_word, 18'h00001);
        // R5 next fetch plain
        step(0, 1, 18'h00010, 18'h00100, 0);
        check("R5 one shot", ir_word, 18'h00010);
        // R8 arming held across gaps
        step(1, 0, '0, '0, 0);
        step(0, 0, '0, '0, 0);
        step(0, 0, '0, '0, 0);
        step(0, 0, '0, '0, 0);
        step(0, 1, 18'h01000, 18'h00020, 0);
        check("R8 held arm", ir_word, 18'h01020);
        // R9 accumulator taken at fetch time
        step(1, 0, '0, 18'h00005, 0);
        step(0, 1, 18'h00200, 18'h00100, 0);
        check("R9 acc at fetch", ir_word, 18'h00300);
        // R6 re-arm on modified fetch
        step(1, 0, '0, '0, 0);
        step(1, 1, 18'h00001, 18'h00001, 0);
        check("R6 first modified", ir_word, 18'h00002);
        step(0, 1, 18'h00004, 18'h00004, 0);
        check("R6 re-armed modified", ir_word, 18'h00008);
        step(0, 1, 18'h00004, 18'h00004, 0);
        check("R6 then plain", ir_word, 18'h00004);
        // R7 flush cancels, even with index_req
        step(1, 0, '0, '0, 0);
        step(1, 0, '0, '0, 1);
        step(0, 1, 18'h00040, 18'h00003, 0);
        check("R7 flush cancels", ir_word, 18'h00040);
        step(1, 0, '0, '0, 0);
        step(0, 1, 18'h00050, 18'h00003, 1);
        check("R7 flush-cycle fetch plain", ir_word, 18'h00050);
        // R3 same word refetched gives original contents
        step(1, 0, '0, '0, 0);
        step(0, 1, 18'h00123, 18'h00001, 0);
        step(0, 1, 18'h00123, 18'h00001, 0);
        check("R3 memory untouched", ir_word, 18'h00123);
        // random traffic, compared every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 3) == 0, $urandom_range(0, 2) != 0,
                 ($urandom_range(0, 7) == 0) ? MASK : W'($urandom),
                 ($urandom_range(0, 7) == 0) ? MASK : W'($urandom),
                 $urandom_range(0, 15) == 0);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule